// File: doc/BRIEF.md
# Temperature Limit Event Monitor

This block watches a stream of 12-bit temperature samples and raises an alarm when one leaves a programmed window or reaches a critical level. A conversion timer asks an external converter for a new sample at a fixed interval. The returned sample arrives on a valid strobe. The block keeps the latest accepted sample in a readable register and compares it, as a signed value, against three programmable limits: an upper window limit, a lower window limit and a critical threshold.

Each accepted sample refreshes one status bit per condition. The alarm output is a pull-low enable, modelled on an open-drain line. It is asserted while any condition holds and alarms are enabled, and it is never a drive-high. Samples that arrive before a power-up delay has elapsed are discarded, so the reading register stays marked not valid until a trustworthy sample exists. A shutdown control stops the timer and freezes the reading and the status.

Software reaches the limits, the control bits, the reading and the status through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `temp_event_monitor`

## Requirements
- R1: After a synchronous reset the register port returns the following values. Address 0 (control) reads 0. Address 1 (upper limit) reads 0x550. Address 2 (lower limit) reads 0x000. Address 3 (critical limit) reads 0x5F0. Address 4 (reading) reads 0: the valid flag is bit 15 and the sample is in bits 11:0. Address 5 (status) reads 0. `evt_pull_low` is 0.
- R2: A strobed sample is discarded until PWRUP_CYCLES clocks after reset release. Until then the valid flag stays 0.
- R3: A sample accepted on a clock edge appears in bits 11:0 of address 4 after that edge, with bit 15 set to 1.
- R4: While running and past the power-up delay, `conv_req` is a one-clock pulse every CONV_CYCLES clocks.
- R5: Status bit 0 is set when the accepted sample, as signed two's complement, is strictly greater than the upper limit.
- R6: Status bit 1 is set when the signed sample is strictly less than the lower limit.
- R7: Status bit 2 is set when the signed sample is greater than or equal to the critical limit.
- R8: Status bits are recomputed on every accepted sample and clear when their condition no longer holds. Limit writes alone do not change them.
- R9: Control bit 0 enables alarms. `evt_pull_low` equals that bit ANDed with the OR of the status bits, one clock later.
- R10: Control bit 1 is shutdown. While it is set, `conv_req` stays 0 and samples are discarded, so the reading and the status hold.
- R11: Writes to address 4 or 5 have no effect. The reading register is written only by samples. Limit writes take bits 11:0 and apply to the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | 12 | Signed sample, 0.0625 degree per LSB |
| conv_req | output | 1 | One-clock conversion request pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| evt_pull_low | output | 1 | Alarm: 1 pulls the open-drain line low, 0 releases it |

## Verification
A wrong comparison or a wrong limit value shows in the status register at the edge that accepts the sample. The alarm output follows one clock later. A wrong power-up counter or shutdown gate shows as a valid flag, or a changed reading, after a sample that should have been discarded. It also shows as a miscounted `conv_req` train. The bench catches each of these within one or two clocks of the stimulus that exposes it. Signed boundary samples, equal to a limit or at the extremes of the 12-bit range, separate an unsigned or off-by-one comparison from a correct one.

// File: rtl/tmon_pkg.sv
// Shared definitions for the temperature limit event monitor.
// Assumes a 3-bit register address space; unused addresses read as zero.
package tmon_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_HIGH = 3'd1,
        A_LOW  = 3'd2,
        A_CRIT = 3'd3,
        A_READ = 3'd4,
        A_STAT = 3'd5
    } reg_addr_e;

    localparam int CTRL_EVT_EN = 0;
    localparam int CTRL_SHDN   = 1;

    // Status word: bit 2 critical, bit 1 below low, bit 0 above high
    typedef struct packed {
        logic crit;
        logic below;
        logic above;
    } tstat_t;
endpackage

// File: rtl/tmon_pacer.sv
// Conversion pacer: counts out the power-up delay after reset, then issues
// a one-clock conversion request every CONV_CYCLES clocks while not shut down.
// Assumes CONV_CYCLES >= 2 and PWRUP_CYCLES >= 1.
module tmon_pacer #(
    parameter int CONV_CYCLES  = 1000,
    parameter int PWRUP_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn,
    output logic pwrup_done,
    output logic conv_req
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int PU_W  = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [PU_W-1:0]  PU_END   = PU_W'(PWRUP_CYCLES);

    logic [PU_W-1:0]  pu_cnt;
    logic [CNT_W-1:0] cv_cnt;
    logic             running;

    assign pwrup_done = (pu_cnt == PU_END);
    assign running    = pwrup_done && !shdn;
    assign conv_req   = running && (cv_cnt == CNT_LAST);

    // Power-up delay counter, saturating at its end value
    always_ff @(posedge clk) begin
        if (!rst_n)          pu_cnt <= '0;
        else if (!pwrup_done) pu_cnt <= pu_cnt + 1'b1;
    end

    // Conversion interval counter, parked at zero while not running
    always_ff @(posedge clk) begin
        if (!rst_n || !running)    cv_cnt <= '0;
        else if (cv_cnt == CNT_LAST) cv_cnt <= '0;
        else                       cv_cnt <= cv_cnt + 1'b1;
    end

    // R4
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R2
    pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_done |=> pwrup_done);
endmodule

// File: rtl/tmon_eval.sv
// Sample evaluator: captures accepted samples and computes the three
// signed limit conditions at the same edge. Assumes limits are stable
// while a sample is accepted; status changes only with a new sample.
module tmon_eval
    import tmon_pkg::*;
#(
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_data,
    input  logic              pwrup_done,
    input  logic              shdn,
    input  logic [TEMP_W-1:0] lim_high,
    input  logic [TEMP_W-1:0] lim_low,
    input  logic [TEMP_W-1:0] lim_crit,
    output logic [TEMP_W-1:0] reading,
    output logic              rd_valid,
    output tstat_t            status
);
    logic   take;
    tstat_t stat_nx;

    assign take = smp_valid && pwrup_done && !shdn;

    // Signed comparison of the incoming sample against each limit
    always_comb begin
        stat_nx.above = $signed(smp_data) >  $signed(lim_high);
        stat_nx.below = $signed(smp_data) <  $signed(lim_low);
        stat_nx.crit  = $signed(smp_data) >= $signed(lim_crit);
    end

    // Reading, valid flag and status registers, loaded on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reading  <= '0;
            rd_valid <= 1'b0;
            status   <= '0;
        end else if (take) begin
            reading  <= smp_data;
            rd_valid <= 1'b1;
            status   <= stat_nx;
        end
    end

    // R3
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (reading == $past(smp_data)) && rd_valid);

    // R2
    no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrup_done |-> !rd_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> $stable(reading) && $stable(status));
endmodule

// File: rtl/tmon_regs.sv
// Register port: holds control bits and the three limits, and returns any
// register on a combinational read. Reading and status are read-only here.
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int TEMP_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [TEMP_W-1:0] reading,
    input  logic              rd_valid,
    input  tstat_t            status,
    output logic              evt_en,
    output logic              shdn,
    output logic [TEMP_W-1:0] lim_high,
    output logic [TEMP_W-1:0] lim_low,
    output logic [TEMP_W-1:0] lim_crit
);
    localparam logic [TEMP_W-1:0] HIGH_RST = TEMP_W'(12'h550);
    localparam logic [TEMP_W-1:0] LOW_RST  = '0;
    localparam logic [TEMP_W-1:0] CRIT_RST = TEMP_W'(12'h5F0);

    // Writable registers: control and limits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_en   <= 1'b0;
            shdn     <= 1'b0;
            lim_high <= HIGH_RST;
            lim_low  <= LOW_RST;
            lim_crit <= CRIT_RST;
        end else if (reg_we) begin
            case (reg_addr_e'(reg_addr))
                A_CTRL: begin
                    evt_en <= reg_wdata[CTRL_EVT_EN];
                    shdn   <= reg_wdata[CTRL_SHDN];
                end
                A_HIGH:  lim_high <= reg_wdata;
                A_LOW:   lim_low  <= reg_wdata;
                A_CRIT:  lim_crit <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            A_CTRL: reg_rdata = {{(DATA_W-2){1'b0}}, shdn, evt_en};
            A_HIGH: reg_rdata = {{(DATA_W-TEMP_W){1'b0}}, lim_high};
            A_LOW:  reg_rdata = {{(DATA_W-TEMP_W){1'b0}}, lim_low};
            A_CRIT: reg_rdata = {{(DATA_W-TEMP_W){1'b0}}, lim_crit};
            A_READ: reg_rdata = {rd_valid, {(DATA_W-1-TEMP_W){1'b0}}, reading};
            A_STAT: reg_rdata = {{(DATA_W-3){1'b0}}, status};
            default: reg_rdata = '0;
        endcase
    end

    // R11
    lim_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(lim_high) && $stable(lim_low) && $stable(lim_crit));
endmodule

// File: rtl/tmon_event.sv
// Alarm driver: registers the gated OR of the status bits into a pull-low
// enable. The output is never a drive-high; 0 means released.
module tmon_event
    import tmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   evt_en,
    input  tstat_t status,
    output logic   evt_pull_low
);
    // Alarm register
    always_ff @(posedge clk) begin
        if (!rst_n) evt_pull_low <= 1'b0;
        else        evt_pull_low <= evt_en && (status != '0);
    end

    // R9
    evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt_en) |-> !evt_pull_low);
endmodule

// File: rtl/temp_event_monitor.sv
// Top of the temperature limit event monitor: pacer, evaluator, register
// port and alarm driver. Assumes DATA_W >= TEMP_W + 1.
module temp_event_monitor
    import tmon_pkg::*;
#(
    parameter int TEMP_W       = 12,
    parameter int DATA_W       = 16,
    parameter int CONV_CYCLES  = 1000,
    parameter int PWRUP_CYCLES = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_data,
    output logic              conv_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              evt_pull_low
);
    logic              pwrup_done;
    logic              evt_en;
    logic              shdn;
    logic [TEMP_W-1:0] lim_high;
    logic [TEMP_W-1:0] lim_low;
    logic [TEMP_W-1:0] lim_crit;
    logic [TEMP_W-1:0] reading;
    logic              rd_valid;
    tstat_t            status;

    tmon_pacer #(.CONV_CYCLES(CONV_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)) u_pacer (
        .clk(clk), .rst_n(rst_n), .shdn(shdn),
        .pwrup_done(pwrup_done), .conv_req(conv_req)
    );

    tmon_eval #(.TEMP_W(TEMP_W)) u_eval (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .pwrup_done(pwrup_done), .shdn(shdn),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit),
        .reading(reading), .rd_valid(rd_valid), .status(status)
    );

    tmon_regs #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reading(reading), .rd_valid(rd_valid), .status(status),
        .evt_en(evt_en), .shdn(shdn),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit)
    );

    tmon_event u_event (
        .clk(clk), .rst_n(rst_n), .evt_en(evt_en), .status(status),
        .evt_pull_low(evt_pull_low)
    );

    // R1
    evt_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !evt_pull_low);
endmodule

// File: tb/temp_event_monitor_tb.sv
module temp_event_monitor_tb;
    localparam int CONV = 16;
    localparam int PWRUP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        conv_req;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        evt_pull_low;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    temp_event_monitor #(.CONV_CYCLES(CONV), .PWRUP_CYCLES(PWRUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .conv_req(conv_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pull_low(evt_pull_low)
    );

    // {sample, expected status {crit, below, above}} with reset limits
    localparam logic [14:0] VEC [8] = '{
        {12'h190, 3'b000}, {12'h551, 3'b001}, {12'h550, 3'b000},
        {12'h5F0, 3'b101}, {12'hFFF, 3'b010}, {12'h800, 3'b010},
        {12'h7FF, 3'b101}, {12'h000, 3'b000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic sample(input logic [11:0] d);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(3'd1, v); check("R1 high", v, 16'h0550);
        rd(3'd2, v); check("R1 low", v, 16'h0000);
        rd(3'd3, v); check("R1 crit", v, 16'h05F0);
        rd(3'd4, v); check("R1 reading", v, 16'h0000);
        rd(3'd5, v); check("R1 status", v, 16'h0000);
        check("R1 evt", {15'd0, evt_pull_low}, 16'h0000);
        // R2 early sample discarded
        sample(12'h123);
        rd(3'd4, v); check("R2 early sample", v, 16'h0000);
        check("R4 no req before pwrup", {15'd0, conv_req}, 16'h0000);
        repeat (PWRUP) @(negedge clk);
        wr(3'd0, 12'h001);
        // Vector walk: R3, R5, R6, R7, R8, R9
        foreach (VEC[i]) begin
            sample(VEC[i][14:3]);
            rd(3'd4, v); check("R3 reading", v, {4'h8, VEC[i][14:3]});
            rd(3'd5, v); check("R5 R6 R7 R8 status", v, {13'd0, VEC[i][2:0]});
            @(negedge clk);
            check("R9 evt", {15'd0, evt_pull_low}, {15'd0, |VEC[i][2:0]});
        end
        // R4 pulse count over a window of 4 periods
        pulses = 0;
        for (int k = 0; k < 4 * CONV; k++) begin
            @(negedge clk);
            if (conv_req) pulses++;
        end
        check("R4 conv pulses", 16'(pulses), 16'd4);
        // R11 limit write, signed low limit -256
        wr(3'd2, 12'hF00);
        rd(3'd5, v); check("R8 limit write keeps status", v, 16'h0000);
        sample(12'hEFF);
        rd(3'd5, v); check("R6 R11 below new low", v, 16'h0002);
        sample(12'hF00);
        rd(3'd5, v); check("R6 equal low", v, 16'h0000);
        wr(3'd4, 12'hABC);
        rd(3'd4, v); check("R11 reading read-only", v, 16'h8F00);
        wr(3'd5, 12'h007);
        rd(3'd5, v); check("R11 status read-only", v, 16'h0000);
        // R9 disable gating
        sample(12'h7FF);
        wr(3'd0, 12'h000);
        @(negedge clk);
        check("R9 disabled evt", {15'd0, evt_pull_low}, 16'h0000);
        rd(3'd5, v); check("R9 status kept", v, 16'h0005);
        // R10 shutdown
        wr(3'd0, 12'h002);
        sample(12'h100);
        rd(3'd4, v); check("R10 reading held", v, 16'h87FF);
        rd(3'd5, v); check("R10 status held", v, 16'h0005);
        pulses = 0;
        for (int k = 0; k < 3 * CONV; k++) begin
            @(negedge clk);
            if (conv_req) pulses++;
        end
        check("R10 no requests", 16'(pulses), 16'd0);
        // R1 reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd2, v); check("R1 low after reset", v, 16'h0000);
        rd(3'd4, v); check("R1 reading after reset", v, 16'h0000);
        rd(3'd0, v); check("R1 ctrl after reset", v, 16'h0000);
        check("R1 evt after reset", {15'd0, evt_pull_low}, 16'h0000);
        finish_run();
    end
endmodule